// File: doc/BRIEF.md
# Pipelined Multi-Table Longest-Prefix Lookup

This block performs longest-prefix-match lookups for several virtual forwarding tables that share one merged binary trie. A request names a table and a destination address. It descends the trie one level per pipeline stage, and each stage owns the node memory for its level. A trie node does not hold next hops. It holds a small bitmap with one bit per table, which marks the tables for which the node ends a prefix. It also holds a base index into a separate next-hop array memory. Prefixes sit on internal nodes because the trie is not leaf-pushed, so the best match seen so far travels down the pipe with the request. After the last level, one read at base plus table number yields the next-hop pointer.

Route changes enter through a separate update port as write bubbles. A bubble takes one pipeline slot and names a target stage, an index and a data word. Only the named stage writes, and it does so as the bubble passes. Lookups that enter before a bubble see the old contents. Lookups that enter after it see the new contents. The engine accepts one request per cycle and returns one result per cycle, in request order.

Top module: `vrt_lpm_pipe`

## Requirements
- R1: Tables share nodes. The same address returns different results for different tables, as set by bit `t` of each node's table bitmap.
- R2: When several nodes on the path have the table's bit set, the deepest one supplies the result.
- R3: If the child selected at a level is marked absent, the descent stops and the match carried so far is returned.
- R4: A hit returns the next-hop array entry at node base plus table number, modulo the array size. When no node on the path has the table's bit set, `rsp_hit` is 0 and `rsp_nexthop` is 0.
- R5: Stage `s` tests address bit `ADDR_W-1-s`, so the most significant bit is tested first. A 0 follows the left child and a 1 follows the right child.
- R6: With the output ready, a lookup is accepted on every cycle. Results emerge in request order, LEVELS+1 cycles after the cycle that captures the request.
- R7: Node word layout, with the least significant bit first: left index (NODE_AW bits), right index (NODE_AW), left valid, right valid, table bitmap (N_TABLES), next-hop base (NH_AW). An update with stage 0..LEVELS-1 writes that level's node memory. Stage LEVELS writes the next-hop array. No other memory changes.
- R8: A lookup accepted before an update sees the old contents. A lookup accepted after the update sees the new contents.
- R9: In a cycle where `upd_valid` is high, `lkp_ready` is low. An update stalls lookup entry for exactly that one cycle.
- R10: While `rsp_ready` is low, a presented result stays valid and unchanged and the pipeline holds. No result is lost.
- R11: After reset, `rsp_valid` is 0 and `lkp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Lookup request present |
| lkp_ready | output | 1 | Lookup request accepted this cycle |
| lkp_table | input | TID_W | Virtual table number |
| lkp_addr | input | ADDR_W | Destination address |
| upd_valid | input | 1 | Write bubble present |
| upd_ready | output | 1 | Write bubble accepted this cycle |
| upd_stage | input | STG_W | Target stage (LEVELS selects the next-hop array) |
| upd_index | input | WA_W | Entry index in the target memory |
| upd_data | input | DATA_W | Word to write |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_hit | output | 1 | A prefix of the table matched |
| rsp_nexthop | output | NH_W | Next-hop pointer |

## Verification
The hardest case to reach from the ports is a bubble placed between two lookups of the same route. The first lookup must return the old next hop and the second the new one. The update must also fall in the exact cycle when a lookup is already waiting at the input. The bench drives a lookup, then in the very next cycle raises the update together with a second copy of the same lookup, and then releases the update. This shows that the lookup waits exactly one cycle and that the two results straddle the change. A frozen output under backpressure is reached by holding `rsp_ready` low while several requests are in flight.

// File: rtl/vrt_lpm_pkg.sv
package vrt_lpm_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_LOOKUP = 2'd1,
    SLOT_WRITE  = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/vrt_lpm_stage.sv
module vrt_lpm_stage
  import vrt_lpm_pkg::*;
#(
  parameter int STAGE    = 0,
  parameter int N_TABLES = 4,
  parameter int ADDR_W   = 8,
  parameter int NODE_AW  = 4,
  parameter int NH_AW    = 6,
  parameter int DATA_W   = 20,
  parameter int STG_W    = 4,
  parameter int WA_W     = 6,
  parameter int TID_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  slot_kind_e        in_kind,
  input  logic [TID_W-1:0]  in_tid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [NODE_AW-1:0] in_node,
  input  logic              in_act,
  input  logic              in_hit,
  input  logic [NH_AW-1:0]  in_base,
  input  logic [STG_W-1:0]  in_wstage,
  input  logic [WA_W-1:0]   in_waddr,
  input  logic [DATA_W-1:0] in_wdata,
  output slot_kind_e        out_kind,
  output logic [TID_W-1:0]  out_tid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [NODE_AW-1:0] out_node,
  output logic              out_act,
  output logic              out_hit,
  output logic [NH_AW-1:0]  out_base,
  output logic [STG_W-1:0]  out_wstage,
  output logic [WA_W-1:0]   out_waddr,
  output logic [DATA_W-1:0] out_wdata
);
  localparam int DEPTH    = 1 << NODE_AW;
  localparam int R_OFF    = NODE_AW;
  localparam int LV_BIT   = 2 * NODE_AW;
  localparam int RV_BIT   = LV_BIT + 1;
  localparam int BM_OFF   = RV_BIT + 1;
  localparam int BASE_OFF = BM_OFF + N_TABLES;
  localparam int NODE_W   = BASE_OFF + NH_AW;
  localparam int ABIT     = ADDR_W - 1 - STAGE;

  logic [NODE_W-1:0] node_mem [DEPTH];
  logic [NODE_W-1:0] word;
  logic [N_TABLES-1:0] bmap;
  logic              go_right;
  logic              child_ok;
  logic [NODE_AW-1:0] child_idx;
  logic              wr_hit;

  logic              nx_act;
  logic              nx_hit;
  logic [NH_AW-1:0]  nx_base;
  logic [NODE_AW-1:0] nx_node;

  assign word      = node_mem[in_node];
  assign bmap      = word[BM_OFF +: N_TABLES];
  assign go_right  = in_addr[ABIT];
  assign child_ok  = go_right ? word[RV_BIT] : word[LV_BIT];
  assign child_idx = go_right ? word[R_OFF +: NODE_AW] : word[0 +: NODE_AW];
  assign wr_hit    = en && (in_kind == SLOT_WRITE) && (in_wstage == STG_W'(STAGE));

  always_comb begin
    nx_act  = in_act;
    nx_hit  = in_hit;
    nx_base = in_base;
    nx_node = '0;
    if (in_kind == SLOT_LOOKUP && in_act) begin
      if (bmap[in_tid]) begin
        nx_hit  = 1'b1;
        nx_base = word[BASE_OFF +: NH_AW];
      end
      if (child_ok) begin
        nx_node = child_idx;
      end else begin
        nx_act  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_kind <= SLOT_IDLE;
    end else if (en) begin
      out_kind <= in_kind;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_tid    <= in_tid;
      out_addr   <= in_addr;
      out_node   <= nx_node;
      out_act    <= nx_act;
      out_hit    <= nx_hit;
      out_base   <= nx_base;
      out_wstage <= in_wstage;
      out_waddr  <= in_waddr;
      out_wdata  <= in_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit) begin
      node_mem[in_waddr[NODE_AW-1:0]] <= in_wdata[NODE_W-1:0];
    end
  end

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_kind == SLOT_LOOKUP && !in_act) |=> (out_kind == SLOT_LOOKUP && !out_act)); // R3
  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_kind == SLOT_LOOKUP && in_hit) |=> out_hit); // R2
endmodule

// File: rtl/vrt_lpm_nh.sv
module vrt_lpm_nh
  import vrt_lpm_pkg::*;
#(
  parameter int LEVELS = 8,
  parameter int NH_AW  = 6,
  parameter int NH_W   = 8,
  parameter int STG_W  = 4,
  parameter int TID_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  slot_kind_e       in_kind,
  input  logic [TID_W-1:0] in_tid,
  input  logic             in_hit,
  input  logic [NH_AW-1:0] in_base,
  input  logic [STG_W-1:0] in_wstage,
  input  logic [NH_AW-1:0] in_waddr,
  input  logic [NH_W-1:0]  in_wdata,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [NH_W-1:0]  rsp_nexthop
);
  localparam int DEPTH = 1 << NH_AW;

  logic [NH_W-1:0]  nh_mem [DEPTH];
  logic [NH_AW-1:0] rd_idx;
  logic [NH_W-1:0]  nx_nh;
  logic             wr_hit;

  assign rd_idx = in_base + NH_AW'(in_tid);
  assign nx_nh  = in_hit ? nh_mem[rd_idx] : '0;
  assign wr_hit = en && (in_kind == SLOT_WRITE) && (in_wstage == STG_W'(LEVELS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (en) begin
      rsp_valid <= (in_kind == SLOT_LOOKUP);
    end
  end

  always_ff @(posedge clk) begin
    if (en && in_kind == SLOT_LOOKUP) begin
      rsp_hit     <= in_hit;
      rsp_nexthop <= nx_nh;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit) begin
      nh_mem[in_waddr] <= in_wdata;
    end
  end

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_nexthop == '0)); // R4
endmodule

// File: rtl/vrt_lpm_pipe.sv
module vrt_lpm_pipe
  import vrt_lpm_pkg::*;
#(
  parameter int N_TABLES = 4,
  parameter int LEVELS   = 8,
  parameter int ADDR_W   = 8,
  parameter int NODE_AW  = 4,
  parameter int NH_AW    = 6,
  parameter int NH_W     = 8,
  localparam int TID_W   = $clog2(N_TABLES),
  localparam int NODE_W  = 2 * NODE_AW + 2 + N_TABLES + NH_AW,
  localparam int DATA_W  = (NODE_W > NH_W) ? NODE_W : NH_W,
  localparam int STG_W   = $clog2(LEVELS + 1),
  localparam int WA_W    = (NODE_AW > NH_AW) ? NODE_AW : NH_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [TID_W-1:0]  lkp_table,
  input  logic [ADDR_W-1:0] lkp_addr,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [STG_W-1:0]  upd_stage,
  input  logic [WA_W-1:0]   upd_index,
  input  logic [DATA_W-1:0] upd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [NH_W-1:0]   rsp_nexthop
);
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync[1];

  slot_kind_e         p_kind   [LEVELS+1];
  logic [TID_W-1:0]   p_tid    [LEVELS+1];
  logic [ADDR_W-1:0]  p_addr   [LEVELS+1];
  logic [NODE_AW-1:0] p_node   [LEVELS+1];
  logic               p_act    [LEVELS+1];
  logic               p_hit    [LEVELS+1];
  logic [NH_AW-1:0]   p_base   [LEVELS+1];
  logic [STG_W-1:0]   p_wstage [LEVELS+1];
  logic [WA_W-1:0]    p_waddr  [LEVELS+1];
  logic [DATA_W-1:0]  p_wdata  [LEVELS+1];

  logic       adv;
  slot_kind_e in_kind_nx;

  assign adv       = !rsp_valid || rsp_ready;
  assign upd_ready = adv;
  assign lkp_ready = adv && !upd_valid;

  always_comb begin
    if (upd_valid)      in_kind_nx = SLOT_WRITE;
    else if (lkp_valid) in_kind_nx = SLOT_LOOKUP;
    else                in_kind_nx = SLOT_IDLE;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      p_kind[0] <= SLOT_IDLE;
    end else if (adv) begin
      p_kind[0] <= in_kind_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      p_tid[0]    <= lkp_table;
      p_addr[0]   <= lkp_addr;
      p_node[0]   <= '0;
      p_act[0]    <= 1'b1;
      p_hit[0]    <= 1'b0;
      p_base[0]   <= '0;
      p_wstage[0] <= upd_stage;
      p_waddr[0]  <= upd_index;
      p_wdata[0]  <= upd_data;
    end
  end

  for (genvar s = 0; s < LEVELS; s++) begin : g_level
    vrt_lpm_stage #(
      .STAGE(s), .N_TABLES(N_TABLES), .ADDR_W(ADDR_W), .NODE_AW(NODE_AW),
      .NH_AW(NH_AW), .DATA_W(DATA_W), .STG_W(STG_W), .WA_W(WA_W), .TID_W(TID_W)
    ) u_stage (
      .clk        (clk),
      .rst_n      (rst_q_n),
      .en         (adv),
      .in_kind    (p_kind[s]),
      .in_tid     (p_tid[s]),
      .in_addr    (p_addr[s]),
      .in_node    (p_node[s]),
      .in_act     (p_act[s]),
      .in_hit     (p_hit[s]),
      .in_base    (p_base[s]),
      .in_wstage  (p_wstage[s]),
      .in_waddr   (p_waddr[s]),
      .in_wdata   (p_wdata[s]),
      .out_kind   (p_kind[s+1]),
      .out_tid    (p_tid[s+1]),
      .out_addr   (p_addr[s+1]),
      .out_node   (p_node[s+1]),
      .out_act    (p_act[s+1]),
      .out_hit    (p_hit[s+1]),
      .out_base   (p_base[s+1]),
      .out_wstage (p_wstage[s+1]),
      .out_waddr  (p_waddr[s+1]),
      .out_wdata  (p_wdata[s+1])
    );
  end

  vrt_lpm_nh #(
    .LEVELS(LEVELS), .NH_AW(NH_AW), .NH_W(NH_W), .STG_W(STG_W), .TID_W(TID_W)
  ) u_nh (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .en          (adv),
    .in_kind     (p_kind[LEVELS]),
    .in_tid      (p_tid[LEVELS]),
    .in_hit      (p_hit[LEVELS]),
    .in_base     (p_base[LEVELS]),
    .in_wstage   (p_wstage[LEVELS]),
    .in_waddr    (p_waddr[LEVELS][NH_AW-1:0]),
    .in_wdata    (p_wdata[LEVELS][NH_W-1:0]),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_nexthop (rsp_nexthop)
  );

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_valid && upd_ready) |-> !(lkp_valid && lkp_ready)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_nexthop) && $stable(rsp_hit))); // R10
  AST_BUBBLE_SILENT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (adv && p_kind[LEVELS] == SLOT_WRITE) |=> !rsp_valid); // R7
endmodule

// File: tb/vrt_lpm_pipe_tb.sv
`timescale 1ns/1ps
module vrt_lpm_pipe_tb;
  localparam int LEVELS = 8;
  localparam int DATA_W = 20;
  localparam int NVEC   = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lkp_valid, lkp_ready;
  logic [1:0]  lkp_table;
  logic [7:0]  lkp_addr;
  logic        upd_valid, upd_ready;
  logic [3:0]  upd_stage;
  logic [5:0]  upd_index;
  logic [DATA_W-1:0] upd_data;
  logic        rsp_valid, rsp_ready, rsp_hit;
  logic [7:0]  rsp_nexthop;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vrt_lpm_pipe u_dut (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_table(lkp_table), .lkp_addr(lkp_addr),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_stage(upd_stage),
    .upd_index(upd_index), .upd_data(upd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_nexthop(rsp_nexthop)
  );

  // {req[3:0], table[1:0], addr[7:0], hit, nexthop[7:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {4'd2, 2'd0, 8'h00, 1'b1, 8'hAC},  // R2 deeper node overrides root
    {4'd1, 2'd1, 8'h00, 1'b1, 8'hAD},  // R1
    {4'd4, 2'd2, 8'h00, 1'b0, 8'h00},  // R4 miss
    {4'd4, 2'd3, 8'h00, 1'b0, 8'h00},  // R4 miss
    {4'd3, 2'd0, 8'h40, 1'b1, 8'hA0},  // R3 absent child keeps root match
    {4'd3, 2'd1, 8'h40, 1'b1, 8'hA5},  // R3
    {4'd5, 2'd2, 8'h80, 1'b1, 8'hAA},  // R5 msb selects right
    {4'd2, 2'd2, 8'hC0, 1'b1, 8'hB6},  // R2
    {4'd1, 2'd3, 8'hC0, 1'b1, 8'hB3},  // R1
    {4'd5, 2'd0, 8'hD0, 1'b1, 8'hB8},  // R5 four-level walk
    {4'd2, 2'd2, 8'hD0, 1'b1, 8'hB6},  // R2
    {4'd4, 2'd1, 8'hD0, 1'b0, 8'h00},  // R4
    {4'd3, 2'd3, 8'hFF, 1'b1, 8'hB3},  // R3
    {4'd5, 2'd0, 8'hFF, 1'b1, 8'hA0}   // R5
  };

  string q_req[$];
  logic [8:0] q_exp[$];
  int q_acc[$];
  bit q_lat[$];

  function automatic string req_name(int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] mk(int l, int r, bit lv, bit rv, logic [3:0] bm, int base);
    return {6'(base), bm, rv, lv, 4'(r), 4'(l)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_exp.size() == 0) begin
        chk(0, "R6", rsp_nexthop, 0);
      end else begin
        string rq;
        logic [8:0] e;
        int acc;
        bit lat;
        rq = q_req.pop_front(); e = q_exp.pop_front();
        acc = q_acc.pop_front(); lat = q_lat.pop_front();
        chk({rsp_hit, rsp_nexthop} == e, rq, {rsp_hit, rsp_nexthop}, e);
        if (lat) chk(cyc - acc == LEVELS + 2, "R6", cyc - acc, LEVELS + 2);
      end
    end
  end

  task automatic send(logic [1:0] t, logic [7:0] a, logic [8:0] e, string rq, bit lat);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_table = t; lkp_addr = a;
    #1;
    while (!lkp_ready) begin @(negedge clk); #1; end
    q_req.push_back(rq); q_exp.push_back(e); q_acc.push_back(cyc); q_lat.push_back(lat);
  endtask

  task automatic idle();
    @(negedge clk);
    lkp_valid = 1'b0;
  endtask

  task automatic upd(int st, int idx, logic [DATA_W-1:0] d);
    @(negedge clk);
    lkp_valid = 1'b0;
    upd_valid = 1'b1; upd_stage = 4'(st); upd_index = 6'(idx); upd_data = d;
    #1;
    while (!upd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && q_exp.size() != 0; i++) @(negedge clk);
    chk(q_exp.size() == 0, "R6", q_exp.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R6 watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lkp_valid = 1'b0; lkp_table = '0; lkp_addr = '0;
    upd_valid = 1'b0; upd_stage = '0; upd_index = '0; upd_data = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R11", rsp_valid, 0);
    chk(lkp_ready == 1'b1, "R11", lkp_ready, 1);

    for (int i = 0; i < 64; i++) upd(LEVELS, i, DATA_W'(8'hA0 + i));
    upd(0, 0, mk(0, 1, 1, 1, 4'b0001, 0));
    upd(1, 0, mk(0, 0, 1, 0, 4'b0010, 4));
    upd(1, 1, mk(0, 1, 0, 1, 4'b0100, 8));
    upd(2, 0, mk(0, 0, 0, 0, 4'b0011, 12));
    upd(2, 1, mk(0, 0, 1, 0, 4'b1000, 16));
    upd(3, 0, mk(0, 0, 0, 1, 4'b0100, 20));
    upd(4, 0, mk(0, 0, 0, 0, 4'b0001, 24));
    repeat (12) @(negedge clk);

    // R6: back-to-back stream of the vector table, latency checked per result
    for (int i = 0; i < NVEC; i++) begin
      int acc0;
      acc0 = cyc;
      send(VEC[i][18:17], VEC[i][16:9], VEC[i][8:0], req_name(int'(VEC[i][22:19])), 1'b1);
      if (i > 0) chk(cyc == acc0 + 1, "R6", cyc - acc0, 1);
    end
    idle();
    drain();

    // R7: node write only in stage 3, then next-hop array write
    upd(3, 0, mk(0, 0, 0, 1, 4'b0110, 20));
    upd(LEVELS, 21, DATA_W'(8'h5A));
    send(2'd1, 8'hD0, {1'b1, 8'h5A}, "R7", 1'b0);
    send(2'd2, 8'hD0, {1'b1, 8'hB6}, "R7", 1'b0);
    send(2'd1, 8'h00, {1'b1, 8'hAD}, "R7", 1'b0);
    idle();
    drain();

    // R8 / R9: lookup, bubble with lookup waiting, same lookup again
    send(2'd0, 8'h00, {1'b1, 8'hAC}, "R8", 1'b0);
    @(negedge clk);
    upd_valid = 1'b1; upd_stage = 4'd2; upd_index = 6'd0; upd_data = mk(0, 0, 0, 0, 4'b0010, 12);
    lkp_valid = 1'b1; lkp_table = 2'd0; lkp_addr = 8'h00;
    #1;
    chk(lkp_ready == 1'b0, "R9", lkp_ready, 0);
    chk(upd_ready == 1'b1, "R9", upd_ready, 1);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    chk(lkp_ready == 1'b1, "R9", lkp_ready, 1);
    q_req.push_back("R8"); q_exp.push_back({1'b1, 8'hA0}); q_acc.push_back(cyc); q_lat.push_back(1'b0);
    send(2'd1, 8'h00, {1'b1, 8'hAD}, "R8", 1'b0);
    idle();
    drain();

    // R10: backpressure holds the result
    rsp_ready = 1'b0;
    send(2'd0, 8'h40, {1'b1, 8'hA0}, "R10", 1'b0);
    send(2'd2, 8'hC0, {1'b1, 8'hB6}, "R10", 1'b0);
    send(2'd3, 8'hFF, {1'b1, 8'hB3}, "R10", 1'b0);
    idle();
    repeat (12) @(negedge clk);
    begin
      bit held;
      held = 1'b1;
      for (int i = 0; i < 6; i++) begin
        if (!(rsp_valid && rsp_hit && rsp_nexthop == 8'hA0)) held = 1'b0;
        @(negedge clk);
      end
      chk(held, "R10", rsp_nexthop, 8'hA0);
      chk(lkp_ready == 1'b0, "R10", lkp_ready, 0);
    end
    rsp_ready = 1'b1;
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule